// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block forms the unsigned product of two 16-bit operands without a multiplier array. It keeps a copy of the first operand and a down-counter loaded with the second. It then adds the first operand into a product register once per clock, and decrements the counter each time, until the counter is empty. A small finite-state controller sequences the work. It issues load, clear and decrement strobes to the datapath and receives back a single flag telling it whether the counter is zero.

Both operands share one input bus. The user pulses `start`, presents the first operand on the following cycle and the second operand on the cycle after that. The block then iterates. A `done` flag rises when the product is final. The product is held until a new `start` or a synchronous reset. A computation with second operand N takes N + 1 iteration cycles, so this block suits places where area matters far more than latency.

Top module: `rep_add_mul`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `done` reads 0 and `prod` reads 0 after that edge.
- R2: `start` high at an edge while idle or done moves the block to operand capture. The value on `din` at the next edge is taken as the first operand (A).
- R3: The value on `din` at the edge after A is captured is taken as the second operand (B), which sets the number of additions.
- R4: The product register is cleared to 0 on the same edge that captures B.
- R5: On each iteration edge where the counter is non-zero, `prod` becomes the previous `prod` plus A. The counter drops by one on the same edge, so exactly B additions occur.
- R6: On the first iteration edge where the counter is zero, `done` rises and `prod` is unchanged. When B is 0, this happens on the edge right after B is captured, with `prod` at 0.
- R7: While `done` is high and `start` is low, `done` stays high and `prod` stays constant.
- R8: Multiplying 5 by 6 ends with `prod` = 30 and `done` = 1.
- R9: The sum keeps only its low 16 bits; carries beyond bit 15 are dropped (300 × 300 gives 24464).
- R10: `start` is ignored while operands are being captured or the loop is running. It does not change the result or the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new multiplication (honoured in idle or done) |
| din | input | 16 | Shared operand bus: A one cycle after start, B the cycle after |
| done | output | 1 | Product is final; held until start or reset |
| prod | output | 16 | Product register, low 16 bits of A × B |

## Verification
Take the edge that samples `start` as edge k. A is taken at edge k+1 and B at edge k+2, where `prod` clears. Partial sums appear after edges k+3 to k+2+B, and `done` rises after edge k+3+B. The bench drives inputs on falling edges and advances a behavioural model on rising edges with the same inputs. It compares `done` and `prod` at every falling edge, so any result that comes one cycle early or late is reported. Explicit end-of-operation checks then confirm final products, the zero-operand shortcut, wrap-around, holding and ignored starts.

// File: rtl/rep_add_mul.sv
module rep_add_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] prod
);

  typedef enum logic [2:0] {S_IDLE, S_LDA, S_LDB, S_LOOP, S_DONE} st_t;

  st_t st, st_n;
  logic [W-1:0] a_q, b_q, p_q;
  logic ld_a, ld_b, ld_p, clr_p, dec_b, b_zero;

  assign b_zero = (b_q == '0);
  assign done   = (st == S_DONE);
  assign prod   = p_q;

  always_comb begin
    st_n  = st;
    ld_a  = 1'b0;
    ld_b  = 1'b0;
    ld_p  = 1'b0;
    clr_p = 1'b0;
    dec_b = 1'b0;
    case (st)
      S_IDLE, S_DONE: if (start) st_n = S_LDA;
      S_LDA: begin
        ld_a = 1'b1;
        st_n = S_LDB;
      end
      S_LDB: begin
        ld_b  = 1'b1;
        clr_p = 1'b1;
        st_n  = S_LOOP;
      end
      S_LOOP: begin
        if (b_zero) st_n = S_DONE;
        else begin
          ld_p  = 1'b1;
          dec_b = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
    end else begin
      if (ld_a)       a_q <= din;
      if (ld_b)       b_q <= din;
      else if (dec_b) b_q <= b_q - 1'b1;
      if (clr_p)      p_q <= '0;
      else if (ld_p)  p_q <= p_q + a_q;
    end
  end

  a_r1_reset: assert property (@(posedge clk) rst |=> (!done && prod == '0));

  a_r2_start_capture: assert property (@(posedge clk) disable iff (rst)
    ((st == S_IDLE || st == S_DONE) && start) |=> (!done && st == S_LDA));

  a_r4_clear_on_b: assert property (@(posedge clk) disable iff (rst)
    (st == S_LDB) |=> (prod == '0));

  a_r3_b_taken: assert property (@(posedge clk) disable iff (rst)
    (st == S_LDB) |=> (b_q == $past(din)));

  a_r5_add_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP && !b_zero) |=>
      (prod == W'($past(prod) + $past(a_q)) && b_q == W'($past(b_q) - 1'b1)));

  a_r6_zero_exit: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP && b_zero) |=> (done && $stable(prod)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(prod)));

  a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP && !b_zero && start) |=> (st == S_LOOP));

endmodule

// File: tb/sim_rep_add_mul.sv
`timescale 1ns/1ps
module sim_rep_add_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] din = '0;
  logic        done;
  logic [15:0] prod;

  int n_run = 0;
  int n_fail = 0;

  int          m_ph = 0;   // 0 idle, 1 want A, 2 want B, 3 loop, 4 finished
  logic [15:0] m_a = '0, m_b = '0, m_p = '0;
  bit          cmp_on = 1'b0;

  always #2 clk = ~clk;

  rep_add_mul u0 (.clk(clk), .rst(rst), .start(start), .din(din), .done(done), .prod(prod));

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_a = '0; m_b = '0; m_p = '0;
    end else begin
      case (m_ph)
        0, 4: if (start) m_ph = 1;
        1: begin m_a = din; m_ph = 2; end
        2: begin m_b = din; m_p = '0; m_ph = 3; end
        3: if (m_b == 0) m_ph = 4;
           else begin m_p = m_p + m_a; m_b = m_b - 1; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(done == (m_ph == 4), (m_ph == 4) ? "R6 done rise" : "R7 done level", done, m_ph == 4);
      check(prod == m_p, (m_ph == 3) ? "R5 partial sum" : "R4 product value", prod, m_p);
    end
  end

  task automatic mul(input logic [15:0] a, input logic [15:0] b, input bit poke);
    @(negedge clk); start = 1'b1; din = 16'hdead;
    @(negedge clk); start = 1'b0; din = a;
    @(negedge clk); din = b;
    @(negedge clk); din = 16'h0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 70000 && !done; i++) @(negedge clk);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0 && prod == 0, "R1 reset state", {done, prod}, 0);
    rst = 1'b0;
    cmp_on = 1'b1;

    mul(16'd5, 16'd6, 1'b0);
    check(done && prod == 30, "R8 five times six", prod, 30);

    mul(16'd7, 16'd2, 1'b0);
    check(prod == 14, "R2 R3 operand order", prod, 14);

    mul(16'd2, 16'd7, 1'b0);
    check(prod == 14, "R3 count from second operand", prod, 14);

    mul(16'd9, 16'd0, 1'b0);
    check(done && prod == 0, "R6 zero second operand", prod, 0);

    mul(16'd0, 16'd5, 1'b0);
    check(done && prod == 0, "R6 zero first operand", prod, 0);

    mul(16'd300, 16'd300, 1'b0);
    check(prod == 16'd24464, "R9 wrap beyond bit 15", prod, 24464);

    repeat (6) @(negedge clk);
    check(done && prod == 16'd24464, "R7 hold after done", prod, 24464);

    mul(16'd11, 16'd20, 1'b1);
    check(done && prod == 220, "R10 start ignored while busy", prod, 220);

    mul(16'd65535, 16'd3, 1'b0);
    check(prod == 16'd65533, "R9 all-ones wrap", prod, 65533);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; din = 16'd4;
    @(negedge clk); din = 16'd50;
    @(negedge clk); din = 16'd0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!done && prod == 0, "R1 reset mid-loop", prod, 0);

    mul(16'd13, 16'd1, 1'b0);
    check(done && prod == 13, "R5 single addition", prod, 13);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule